// File: doc/BRIEF.md
# Convolutional Symbol Interleaver / Deinterleaver

This block spreads a stream of symbols over time so that a burst of channel errors lands on symbols that lie far apart once the order is restored. It has a number of branches, each a first-in first-out delay line of a different depth. A single selector picks one branch for each accepted symbol. The symbol enters that branch, and the oldest symbol of the same branch leaves at the output in the same cycle. The selector then moves on to the next branch and wraps from the last branch back to the first.

A build-time mode picks one of two depth profiles. In the spreading mode, depth grows with the branch index. In the restoring mode it shrinks, so that one instance of each mode in series delays every symbol by the same amount. A build-time table can replace both profiles with any set of depths. A functional input returns the selector to the first branch and leaves every stored symbol in place. The chip-level reset clears the stored symbols to zero.

Top module: `cil_top`

## Requirements
- R1: After `rst_n` is released, the selector points at branch 0, every stored symbol is zero, and `dout_vld` is low while `din_vld` is low.
- R2: With MODE = interleave (0), branch i delays by i*STEP of its own visits. A symbol written on a visit to branch i leaves on the i*STEP-th later visit to that branch.
- R3: With MODE = deinterleave (1), branch i delays by (NB-1-i)*STEP of its own visits.
- R4: A branch of depth zero drives `din` onto `dout` combinationally, in the same cycle.
- R5: The selector advances by exactly one branch per cycle with `din_vld` high, wraps from NB-1 to 0, and holds during idle cycles.
- R6: `dout_vld` equals `din_vld` in the same cycle, and `dout` is taken from the branch being visited.
- R7: A cycle with `arm_rst` high returns the selector to branch 0 and leaves all stored symbols unchanged.
- R8: When `arm_rst` and `din_vld` are both high, the symbol goes to branch 0 and the next symbol goes to branch 1.
- R9: With USE_TAB = 1, the depth of branch i is the 8-bit field LEN_TAB[8*i+7:8*i], and MODE has no effect.
- R10: An interleave instance followed by a deinterleave instance with the same NB and STEP returns the input stream delayed by STEP*NB*(NB-1) symbols. The first symbols out are the zeros cleared by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; clears selector and stored symbols |
| arm_rst | input | 1 | Returns the selector to branch 0; stored symbols are kept |
| din_vld | input | 1 | Input symbol strobe |
| din | input | DW | Input symbol |
| dout_vld | output | 1 | Output symbol strobe |
| dout | output | DW | Output symbol |

## Verification
The two functions that can fall in the same cycle are the selector return and the acceptance of a symbol. The bench raises `arm_rst` together with `din_vld` while the selector points at a middle branch, and also does so on two cycles in a row. A behavioural model with one queue per branch decides that the symbol is exchanged with branch 0 and that the following symbol goes to branch 1. Every output is compared with the model on every cycle. The bench also raises `arm_rst` alone and then shows through later outputs that no stored symbol was lost.

// File: rtl/cil_pkg.sv
package cil_pkg;

  typedef enum logic {
    CIL_INTERLEAVE   = 1'b0,
    CIL_DEINTERLEAVE = 1'b1
  } cil_mode_e;

  // width of one depth field in the explicit depth table
  localparam int CIL_LEN_W = 8;

  // depth of a branch under the two built-in profiles
  function automatic int cil_profile_len(input int idx, input int nb,
                                         input int step, input cil_mode_e mode);
    if (mode == CIL_INTERLEAVE) return idx * step;
    return (nb - 1 - idx) * step;
  endfunction

endpackage

// File: rtl/cil_arm.sv
module cil_arm #(
  parameter int NB = 4,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          step_i,
  input  logic          clr_i,
  output logic [IW-1:0] sel_o
);

  logic [IW-1:0] arm_q;
  logic [IW-1:0] arm_d;
  logic [IW-1:0] sel;

  // branch used this cycle: a return request takes effect at once
  always_comb begin
    sel = clr_i ? '0 : arm_q;
    if (step_i) begin
      if (sel == IW'(NB - 1)) arm_d = '0;
      else                    arm_d = sel + 1'b1;
    end else begin
      arm_d = sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_q <= '0;
    else if (step_i || clr_i) arm_q <= arm_d;
  end

  assign sel_o = sel;

  AST_ARM_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && !clr_i) |=> (arm_q == (($past(arm_q) == IW'(NB - 1)) ? IW'(0) : IW'($past(arm_q) + 1'b1)))); // R5

  AST_ARM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !clr_i) |=> $stable(arm_q)); // R5

  AST_ARM_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !step_i) |=> (arm_q == '0)); // R7

  AST_ARM_CLR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && step_i) |=> (arm_q == IW'(1 % NB))); // R8

endmodule

// File: rtl/cil_branch.sv
module cil_branch #(
  parameter int DW  = 8,
  parameter int LEN = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic [DW-1:0] din_i,
  output logic [DW-1:0] dout_o
);

  // slot 0 is the newest symbol, slot LEN-1 the oldest
  logic [LEN-1:0][DW-1:0] sr_q;
  logic [LEN-1:0][DW-1:0] sr_d;

  always_comb begin
    sr_d[0] = din_i;
    for (int k = 1; k < LEN; k++) sr_d[k] = sr_q[k-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= '0;
    else if (en_i) sr_q <= sr_d;
  end

  assign dout_o = sr_q[LEN-1];

  AST_BR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> $stable(sr_q)); // R7

  AST_BR_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    en_i |=> (sr_q[0] == $past(din_i))); // R2

endmodule

// File: rtl/cil_omux.sv
module cil_omux #(
  parameter int NB = 4,
  parameter int DW = 8,
  parameter int IW = 2
) (
  input  logic [DW-1:0] tail_i [NB],
  input  logic [IW-1:0] sel_i,
  output logic [DW-1:0] dout_o
);

  always_comb begin
    dout_o = '0;
    for (int i = 0; i < NB; i++) begin
      if (sel_i == IW'(i)) dout_o = tail_i[i];
    end
  end

endmodule

// File: rtl/cil_top.sv
module cil_top
  import cil_pkg::*;
#(
  parameter int                      NB      = 4,
  parameter int                      STEP    = 2,
  parameter int                      DW      = 8,
  parameter cil_mode_e               MODE    = CIL_INTERLEAVE,
  parameter bit                      USE_TAB = 1'b0,
  parameter logic [NB*CIL_LEN_W-1:0] LEN_TAB = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_rst,
  input  logic          din_vld,
  input  logic [DW-1:0] din,
  output logic          dout_vld,
  output logic [DW-1:0] dout
);

  localparam int IW = (NB > 1) ? $clog2(NB) : 1;

  logic [IW-1:0] sel;
  logic [DW-1:0] br_tail [NB];

  cil_arm #(.NB(NB), .IW(IW)) u_arm (
    .clk    (clk),
    .rst_n  (rst_n),
    .step_i (din_vld),
    .clr_i  (arm_rst),
    .sel_o  (sel)
  );

  for (genvar g = 0; g < NB; g++) begin : g_br
    localparam int LEN = USE_TAB ? int'(LEN_TAB[g*CIL_LEN_W +: CIL_LEN_W])
                                 : cil_profile_len(g, NB, STEP, MODE);
    if (LEN == 0) begin : g_pass
      assign br_tail[g] = din;
    end else begin : g_sr
      logic br_en;
      assign br_en = din_vld && (sel == IW'(g));
      cil_branch #(.DW(DW), .LEN(LEN)) u_br (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (br_en),
        .din_i  (din),
        .dout_o (br_tail[g])
      );
    end
  end

  cil_omux #(.NB(NB), .DW(DW), .IW(IW)) u_omux (
    .tail_i (br_tail),
    .sel_i  (sel),
    .dout_o (dout)
  );

  assign dout_vld = din_vld;

  AST_SEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    din_vld |-> (int'(sel) < NB)); // R5

endmodule

// File: tb/cil_top_tb.sv
module cil_top_tb;
  import cil_pkg::*;

  localparam int NB = 4;
  localparam int ST = 2;
  localparam int DW = 8;
  localparam int DLY = ST * NB * (NB - 1);
  localparam logic [NB*8-1:0] TAB = {8'd5, 8'd1, 8'd0, 8'd3};

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n;
  logic          arm_rst;
  logic          din_vld;
  logic [DW-1:0] din;
  logic          v0, v1, v2;
  logic [DW-1:0] q0, q1, q2;

  cil_top #(.NB(NB), .STEP(ST), .DW(DW), .MODE(CIL_INTERLEAVE)) u_dut (
    .clk(clk), .rst_n(rst_n), .arm_rst(arm_rst), .din_vld(din_vld), .din(din),
    .dout_vld(v0), .dout(q0));

  cil_top #(.NB(NB), .STEP(ST), .DW(DW), .MODE(CIL_DEINTERLEAVE)) u_deint (
    .clk(clk), .rst_n(rst_n), .arm_rst(arm_rst), .din_vld(v0), .din(q0),
    .dout_vld(v1), .dout(q1));

  cil_top #(.NB(NB), .STEP(ST), .DW(DW), .MODE(CIL_DEINTERLEAVE),
            .USE_TAB(1'b1), .LEN_TAB(TAB)) u_tab (
    .clk(clk), .rst_n(rst_n), .arm_rst(arm_rst), .din_vld(din_vld), .din(din),
    .dout_vld(v2), .dout(q2));

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // reference model state
  int            lens [3][NB];
  logic [DW-1:0] bq   [3][NB][$];
  int            arm_m[3];
  logic [DW-1:0] hist [$];
  bit            chain_ok;
  bit            after_idle;
  bit            pend_ar;
  int            nvalid;

  task automatic chk(input string tag, input int k, input logic [DW-1:0] act,
                     input logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s inst%0d: got %h expected %h", tag, k, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int k = 0; k < 3; k++) begin
      arm_m[k] = 0;
      for (int i = 0; i < NB; i++) begin
        bq[k][i].delete();
        for (int j = 0; j < lens[k][i]; j++) bq[k][i].push_back('0);
      end
    end
    hist.delete();
    nvalid = 0;
  endtask

  task automatic model_step(input int k, input bit v, input bit ar,
                            input logic [DW-1:0] d, output logic [DW-1:0] e,
                            output int idx);
    idx = ar ? 0 : arm_m[k];
    e = '0;
    if (v) begin
      if (lens[k][idx] == 0) e = d;
      else begin
        e = bq[k][idx].pop_front();
        bq[k][idx].push_back(d);
      end
      arm_m[k] = (idx == NB - 1) ? 0 : idx + 1;
    end else begin
      arm_m[k] = idx;
    end
  endtask

  task automatic cyc(input bit v, input bit ar, input logic [DW-1:0] d);
    logic [DW-1:0] e [3];
    logic [DW-1:0] act [3];
    logic          av [3];
    int            idx [3];
    string         tag;
    @(negedge clk);
    din_vld = v;
    arm_rst = ar;
    din     = d;
    #1;
    model_step(0, v, ar, d, e[0], idx[0]);
    model_step(1, v, ar, e[0], e[1], idx[1]);
    model_step(2, v, ar, d, e[2], idx[2]);
    act[0] = q0; act[1] = q1; act[2] = q2;
    av[0] = v0;  av[1] = v1;  av[2] = v2;
    for (int k = 0; k < 3; k++) begin
      chk("R6", k, {7'd0, av[k]}, {7'd0, v});
      if (v) begin
        if (ar)                       tag = "R8";
        else if (pend_ar)             tag = "R7";
        else if (after_idle)          tag = "R5";
        else if (lens[k][idx[k]] == 0) tag = "R4";
        else if (nvalid < NB)         tag = "R1";
        else if (k == 0)              tag = "R2";
        else if (k == 1)              tag = "R3";
        else                          tag = "R9";
        chk(tag, k, act[k], e[k]);
      end
    end
    if (v && chain_ok) begin
      hist.push_back(d);
      // R10: end-to-end delay through both instances
      if (hist.size() > DLY) chk("R10", 1, q1, hist[hist.size() - 1 - DLY]);
      else                   chk("R10", 1, q1, '0);
    end
    if (v) begin
      nvalid++;
      after_idle = 1'b0;
      pend_ar = 1'b0;
    end else begin
      after_idle = 1'b1;
      if (ar) pend_ar = 1'b1;
    end
  endtask

  initial begin
    for (int i = 0; i < NB; i++) begin
      lens[0][i] = i * ST;
      lens[1][i] = (NB - 1 - i) * ST;
      lens[2][i] = int'(TAB[i*8 +: 8]);
    end
    rst_n = 1'b0; arm_rst = 1'b0; din_vld = 1'b0; din = '0;
    chain_ok = 1'b1; after_idle = 1'b0; pend_ar = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: idle after reset gives no output strobe
    #1;
    chk("R1", 0, {7'd0, v0}, 8'd0);
    chk("R1", 2, {7'd0, v2}, 8'd0);
    after_idle = 1'b0;
    // phase A: steady stream with idle gaps, chain alignment intact
    for (int i = 0; i < 150; i++) begin
      if (i % 9 == 8) cyc(1'b0, 1'b0, 8'hEE);
      cyc(1'b1, 1'b0, DW'(i * 7 + 3));
    end
    // phase B: selector returns; alignment of the chain no longer guaranteed
    chain_ok = 1'b0;
    cyc(1'b1, 1'b0, 8'h11);
    cyc(1'b1, 1'b0, 8'h22);
    cyc(1'b0, 1'b1, 8'h00);            // R7: return alone
    for (int i = 0; i < 20; i++) cyc(1'b1, 1'b0, DW'(8'h40 + i));
    cyc(1'b1, 1'b0, 8'hA1);
    cyc(1'b1, 1'b1, 8'hA2);            // R8: return with a symbol
    for (int i = 0; i < 20; i++) cyc(1'b1, 1'b0, DW'(8'h80 + i));
    cyc(1'b1, 1'b1, 8'hB1);            // R8: twice in a row
    cyc(1'b1, 1'b1, 8'hB2);
    for (int i = 0; i < 12; i++) cyc(1'b1, 1'b0, DW'(8'hC0 + i));
    cyc(1'b0, 1'b1, 8'h00);
    cyc(1'b0, 1'b0, 8'h00);
    for (int i = 0; i < 12; i++) cyc(1'b1, 1'b0, DW'(8'hD0 + i));
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule